// File: doc/BRIEF.md
# Slot network interrupt aggregator

This block gathers per-port network interrupt requests coming from up to seven module slots, each slot carrying up to four ports. Each request arrives as a one-cycle set or clear pulse tagged with a slot number and a port number. The block keeps the requests as bits in packed status words, drives a single combined interrupt line towards the CPU's interrupt controller, and lets the CPU read the status words through a simple synchronous read port.

A layout input selects one of two chassis arrangements. In the compact arrangement only four slots exist. All of their bits live in one 32-bit word, which the CPU reads as four byte-wide windows whose address order does not follow slot order. In the extended arrangement seven slots exist. Slots 1 to 6 share the first word in 4-bit groups at irregular positions, slot 0 sits alone in a second word, and each word is read whole.

Top module: `netirq_collector`

## Requirements
- R1: In compact layout (`layout_ext`=0) a request for slot s, port p sets or clears bit base(s)+p of word A, where base is 16, 24, 0 and 8 for slots 0, 1, 2 and 3 respectively.
- R2: In extended layout (`layout_ext`=1) a request for slot 0, port p addresses bit p of word B. Slots 1, 2, 3, 4, 5 and 6 address word A at bases 24, 16, 28, 20, 8 and 0 plus p.
- R3: A set pulse ORs its bit in and a clear pulse removes only its own bit. When a set and a clear target the same bit in the same cycle, the bit ends up set. A set and a clear on different bits in one cycle both take effect.
- R4: `irq_out` is a register. It is high exactly when word A is nonzero or, in extended layout only, word B is nonzero, judged on the status one cycle earlier. A set sampled at clock edge k therefore raises `irq_out` at edge k+2. In compact layout, word B never raises `irq_out`.
- R5: In compact layout a read at address 0, 1, 2 or 3 returns word A bits [31:24], [23:16], [15:8] or [7:0], zero-extended to 32 bits. These are the windows for slots 1, 0, 3 and 2.
- R6: In extended layout, address 4 returns word A and address 5 returns word B. Any address not listed for the active layout reads 0. `rd_data` is registered: it shows the status sampled with `rd_en` one clock later, and it is 0 in the cycle after a clock where `rd_en` was low.
- R7: Requests for slots 4 to 7 in compact layout, or for slot 7 in extended layout, are ignored: no status bit and no interrupt change.
- R8: Synchronous reset clears both status words, `irq_out` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| layout_ext | input | 1 | 0 = compact four-slot layout, 1 = extended seven-slot layout |
| set_vld | input | 1 | Set request pulse |
| set_slot | input | 3 | Slot number of the set request |
| set_port | input | 2 | Port number of the set request |
| clr_vld | input | 1 | Clear request pulse |
| clr_slot | input | 3 | Slot number of the clear request |
| clr_port | input | 2 | Port number of the clear request |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Combined network interrupt |

## Verification
The hardest situation to reach from the ports is a word-B bit left pending while the layout changes. In that case the interrupt must drop even though status is still held. The stimulus raises slot 0 in extended layout, flips `layout_ext` to compact without a reset, and expects `irq_out` low two edges later. A second difficult case is a set and a clear hitting the same bit in one cycle. The driver issues both pulses on one clock edge, and the scoreboard then expects the bit still present in the read window.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

  localparam int COMPACT_SLOTS = 4;
  localparam int EXT_SLOTS     = 7;

  // slot exists in the selected layout
  function automatic logic slot_ok(input logic ext, input int slot);
    return ext ? (slot < EXT_SLOTS) : (slot < COMPACT_SLOTS);
  endfunction

  // slot lives in the second status word
  function automatic logic uses_word_b(input logic ext, input int slot);
    return ext && (slot == 0);
  endfunction

  // base bit of a slot's port group inside its word
  function automatic int slot_base(input logic ext, input int slot);
    int b;
    b = 0;
    if (ext) begin
      case (slot)
        1: b = 24;
        2: b = 16;
        3: b = 28;
        4: b = 20;
        5: b = 8;
        default: b = 0;
      endcase
    end else begin
      case (slot)
        0: b = 16;
        1: b = 24;
        3: b = 8;
        default: b = 0;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/netirq_bitsel.sv
module netirq_bitsel #(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 3,
  parameter int PORT_W = 2
) (
  input  logic              ext,
  input  logic              vld,
  input  logic [SLOT_W-1:0] slot,
  input  logic [PORT_W-1:0] port,
  output logic [WORD_W-1:0] mask_a,
  output logic [WORD_W-1:0] mask_b
);
  import netirq_pkg::*;

  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  always_comb begin
    mask_a = '0;
    mask_b = '0;
    if (vld && slot_ok(ext, int'(slot))) begin
      if (uses_word_b(ext, int'(slot)))
        mask_b = ONE << port;
      else
        mask_a = ONE << (slot_base(ext, int'(slot)) + int'(port));
    end
  end

endmodule

// File: rtl/netirq_state.sv
module netirq_state #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext,
  input  logic [WORD_W-1:0] set_a,
  input  logic [WORD_W-1:0] set_b,
  input  logic [WORD_W-1:0] clr_a,
  input  logic [WORD_W-1:0] clr_b,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b,
  output logic              irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_a <= '0;
      word_b <= '0;
      irq    <= 1'b0;
    end else begin
      // clear first, set last: a same-bit collision keeps the bit
      word_a <= (word_a & ~clr_a) | set_a;
      word_b <= (word_b & ~clr_b) | set_b;
      irq    <= (|word_a) | (ext & (|word_b));
    end
  end

endmodule

// File: rtl/netirq_rdport.sv
module netirq_rdport #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic [WORD_W-1:0] rd_data
);
  localparam int N_LANES = WORD_W / BYTE_W;
  localparam int LANE_W  = $clog2(N_LANES);
  localparam logic [ADDR_W-1:0] ADDR_WA = ADDR_W'(N_LANES);
  localparam logic [ADDR_W-1:0] ADDR_WB = ADDR_W'(N_LANES + 1);

  logic [WORD_W-1:0] lane [N_LANES];
  logic [WORD_W-1:0] nxt;

  // lane g shows the byte that sits g bytes below the top of word A
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign lane[g] = WORD_W'(word_a[WORD_W-1-g*BYTE_W -: BYTE_W]);
  end

  always_comb begin
    nxt = '0;
    if (!ext) begin
      if (rd_addr < ADDR_WA)
        nxt = lane[rd_addr[LANE_W-1:0]];
    end else if (rd_addr == ADDR_WA) begin
      nxt = word_a;
    end else if (rd_addr == ADDR_WB) begin
      nxt = word_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rd_data <= '0;
    else               rd_data <= nxt;
  end

endmodule

// File: rtl/netirq_collector.sv
module netirq_collector #(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int SLOT_W  = 3,
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 3,
  localparam int PORT_W = $clog2(N_PORTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              layout_ext,
  input  logic              set_vld,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic [PORT_W-1:0] set_port,
  input  logic              clr_vld,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic [PORT_W-1:0] clr_port,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_out
);
  localparam int N_EV = 2;  // index 0: set, index 1: clear

  logic              ev_vld  [N_EV];
  logic [SLOT_W-1:0] ev_slot [N_EV];
  logic [PORT_W-1:0] ev_port [N_EV];
  logic [WORD_W-1:0] ev_ma   [N_EV];
  logic [WORD_W-1:0] ev_mb   [N_EV];
  logic [WORD_W-1:0] word_a, word_b;

  assign ev_vld[0]  = set_vld;
  assign ev_slot[0] = set_slot;
  assign ev_port[0] = set_port;
  assign ev_vld[1]  = clr_vld;
  assign ev_slot[1] = clr_slot;
  assign ev_port[1] = clr_port;

  for (genvar e = 0; e < N_EV; e++) begin : g_dec
    netirq_bitsel #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .PORT_W(PORT_W)) u_sel (
      .ext    (layout_ext),
      .vld    (ev_vld[e]),
      .slot   (ev_slot[e]),
      .port   (ev_port[e]),
      .mask_a (ev_ma[e]),
      .mask_b (ev_mb[e])
    );
  end

  netirq_state #(.WORD_W(WORD_W)) u_state (
    .clk    (clk),
    .rst    (rst),
    .ext    (layout_ext),
    .set_a  (ev_ma[0]),
    .set_b  (ev_mb[0]),
    .clr_a  (ev_ma[1]),
    .clr_b  (ev_mb[1]),
    .word_a (word_a),
    .word_b (word_b),
    .irq    (irq_out)
  );

  netirq_rdport #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .ext     (layout_ext),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .word_a  (word_a),
    .word_b  (word_b),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/netirq_collector_chk.sv
module netirq_collector_chk #(
  parameter int WORD_W = 32,
  parameter int SLOT_W = 3,
  parameter int PORT_W = 2,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              layout_ext,
  input logic              set_vld,
  input logic [SLOT_W-1:0] set_slot,
  input logic [PORT_W-1:0] set_port,
  input logic              clr_vld,
  input logic [SLOT_W-1:0] clr_slot,
  input logic [PORT_W-1:0] clr_port,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WORD_W-1:0] rd_data,
  input logic              irq_out
);
  import netirq_pkg::*;

  logic set_taken, same_bit;
  assign set_taken = set_vld && slot_ok(layout_ext, int'(set_slot));
  assign same_bit  = clr_vld && (clr_slot == set_slot) && (clr_port == set_port);

  // R4: an accepted set raises the interrupt two edges later
  p_set_raises_irq_r4: assert property (@(posedge clk) disable iff (rst)
    set_taken ##1 (layout_ext == $past(layout_ext)) |=> irq_out);

  // R3: a same-bit clear in the same cycle does not cancel the set
  p_set_beats_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (set_taken && same_bit) ##1 (layout_ext == $past(layout_ext)) |=> irq_out);

  // R4: with no new set and no layout change, a low interrupt stays low
  p_quiet_stays_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!irq_out && !$past(set_vld) && $stable(layout_ext)) |=> !irq_out);

  // R6: read data is zero after a cycle without a read strobe
  p_idle_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

  // R8: one cycle after reset, outputs are cleared
  p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && rd_data == '0));

endmodule

bind netirq_collector netirq_collector_chk #(
  .WORD_W(WORD_W), .SLOT_W(SLOT_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .layout_ext(layout_ext),
  .set_vld(set_vld), .set_slot(set_slot), .set_port(set_port),
  .clr_vld(clr_vld), .clr_slot(clr_slot), .clr_port(clr_port),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
);

// File: tb/netirq_collector_tb_top.sv
module netirq_collector_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        layout_ext = 1'b0;
  logic        set_vld = 1'b0, clr_vld = 1'b0, rd_en = 1'b0;
  logic [2:0]  set_slot = '0, clr_slot = '0, rd_addr = '0;
  logic [1:0]  set_port = '0, clr_port = '0;
  logic [31:0] rd_data;
  logic        irq_out;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] ma = '0, mb = '0;   // expected word A / word B
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        fire;

  always #5 clk = ~clk;

  netirq_collector dut_i (
    .clk(clk), .rst(rst), .layout_ext(layout_ext),
    .set_vld(set_vld), .set_slot(set_slot), .set_port(set_port),
    .clr_vld(clr_vld), .clr_slot(clr_slot), .clr_port(clr_port),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected {B,A} masks per R1/R2/R7
  function automatic logic [63:0] bmask(input logic e, input int s, input int p);
    logic [31:0] a, b;
    a = '0; b = '0;
    if (e) begin
      case (s)
        0: b[p] = 1'b1;
        1: a[24+p] = 1'b1;
        2: a[16+p] = 1'b1;
        3: a[28+p] = 1'b1;
        4: a[20+p] = 1'b1;
        5: a[8+p]  = 1'b1;
        6: a[p]    = 1'b1;
        default: ;
      endcase
    end else begin
      case (s)
        0: a[16+p] = 1'b1;
        1: a[24+p] = 1'b1;
        2: a[p]    = 1'b1;
        3: a[8+p]  = 1'b1;
        default: ;
      endcase
    end
    return {b, a};
  endfunction

  function automatic logic [31:0] exp_rd(input int adr);
    if (!layout_ext) begin
      case (adr)
        0: return {24'h0, ma[31:24]};
        1: return {24'h0, ma[23:16]};
        2: return {24'h0, ma[15:8]};
        3: return {24'h0, ma[7:0]};
        default: return '0;
      endcase
    end
    if (adr == 4) return ma;
    if (adr == 5) return mb;
    return '0;
  endfunction

  function automatic logic exp_irq();
    return (|ma) | (layout_ext & (|mb));
  endfunction

  // one request cycle; returns at the negedge after the capturing edge
  task automatic op(input logic sv, input int ss, input int sp,
                    input logic cv, input int cs, input int cp);
    logic [63:0] m;
    @(negedge clk);
    set_vld = sv; set_slot = 3'(ss); set_port = 2'(sp);
    clr_vld = cv; clr_slot = 3'(cs); clr_port = 2'(cp);
    if (cv) begin m = bmask(layout_ext, cs, cp); ma &= ~m[31:0]; mb &= ~m[63:32]; end
    if (sv) begin m = bmask(layout_ext, ss, sp); ma |= m[31:0];  mb |= m[63:32]; end
    @(negedge clk);
    set_vld = 1'b0; clr_vld = 1'b0;
  endtask

  task automatic rd(input int adr, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'(adr);
    exp_q.push_back(exp_rd(adr));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 8; a++) rd(a, tag);
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk);
    chk(tag, 32'(irq_out), 32'(exp_irq()));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ma = '0; mb = '0;
  endtask

  // monitor: compare read data one edge after the strobe
  always @(posedge clk) begin
    fire = rd_en;
    #2;
    if (fire) begin
      if (exp_q.size() == 0) chk("R6 unexpected read", 32'hDEAD, 32'h0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 10);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R8 irq after reset", 32'(irq_out), 32'h0);
    chk("R8 rd_data after reset", rd_data, 32'h0);
    rd_all("R8 reads after reset");

    // compact layout, R1 placement and R4 timing
    op(1, 0, 1, 0, 0, 0);
    chk("R4 irq still low one edge after set", 32'(irq_out), 32'h0);
    chk_irq("R4 irq high two edges after set");
    op(1, 1, 3, 0, 0, 0);
    op(1, 2, 0, 0, 0, 0);
    op(1, 3, 2, 0, 0, 0);
    rd_all("R1 R5 compact windows");
    // R7: nonexistent compact slots
    op(1, 5, 1, 0, 0, 0);
    op(1, 4, 3, 0, 0, 0);
    op(1, 7, 0, 0, 0, 0);
    rd_all("R7 compact slots 4-7 ignored");
    // R3: clear only its bit, same-bit collision, split collision
    op(0, 0, 0, 1, 0, 1);
    rd(1, "R3 clear removes slot0 port1");
    rd(0, "R3 clear leaves slot1");
    op(1, 2, 1, 1, 2, 1);
    rd(3, "R3 set wins same bit");
    op(1, 3, 0, 1, 2, 0);
    rd(3, "R3 clear of other bit applied");
    rd(2, "R3 set of other bit applied");
    op(0, 0, 0, 1, 1, 3);
    op(0, 0, 0, 1, 2, 1);
    op(0, 0, 0, 1, 3, 0);
    chk_irq("R4 irq one edge after last clear");
    op(0, 0, 0, 1, 3, 2);
    chk("R4 irq still high before clear seen", 32'(irq_out), 32'h1);
    chk_irq("R4 irq low after all cleared");
    // R8 mid-state reset
    op(1, 1, 2, 0, 0, 0);
    op(1, 3, 3, 0, 0, 0);
    chk_irq("R4 irq before reset");
    do_reset();
    chk("R8 irq cleared by reset", 32'(irq_out), 32'h0);
    rd_all("R8 status cleared by reset");

    // extended layout, R2 placement
    @(negedge clk); rst = 1'b1; layout_ext = 1'b1;
    @(negedge clk); rst = 1'b0;
    op(1, 0, 2, 0, 0, 0);
    chk_irq("R4 word B raises irq in extended");
    for (int s = 1; s < 7; s++) op(1, s, (s + 1) % 4, 0, 0, 0);
    rd_all("R2 R6 extended words");
    op(1, 7, 3, 0, 0, 0);
    rd(4, "R7 slot 7 ignored word A");
    rd(5, "R7 slot 7 ignored word B");
    for (int s = 1; s < 7; s++) op(0, 0, 0, 1, s, (s + 1) % 4);
    rd(4, "R3 extended word A cleared");
    rd(5, "R3 word B untouched");
    chk_irq("R4 irq held by word B only");
    // R4: word B does not count in compact layout
    @(negedge clk); layout_ext = 1'b0;
    @(negedge clk);
    chk_irq("R4 compact ignores word B");
    rd(0, "R6 compact window after layout change");
    @(negedge clk); layout_ext = 1'b1;
    op(0, 0, 0, 1, 0, 2);
    rd(5, "R2 word B cleared");
    chk_irq("R4 irq low in extended when empty");

    repeat (4) @(negedge clk);
    chk("R6 read queue drained", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule